// File: doc/BRIEF.md
# Quadrature Decoder with Revolution Counting

This block turns the two phase signals of an incremental rotary encoder, plus an optional index mark, into a position count and a revolution count. Every legal edge on either phase moves the position by one step (four counts per encoder line). The position climbs to a programmable top value and wraps back to zero, and each such wrap advances the revolution count. Counting backwards past zero reloads the top value and takes one off the revolution count. The index mark can clear the position, but only when the two phases are in a chosen state. This keeps the reference point fixed to one edge of the encoder line.

The phase and index inputs pass through a two-stage synchronizer. They then pass through a glitch filter that software can bypass when the encoder runs close to half the block clock rate. A compare unit watches the position alone, the revolution alone, or both together. When the counts first reach the programmed values, it issues a one-cycle event pulse and sets a sticky interrupt flag. A mask bit gates that flag onto the interrupt pin.

Software reaches the block through a four-word write/read port. Word 0 is control and status. Word 1 is the position top. Word 2 is the compare value. Word 3 is the live count, which can also be loaded.

Top module: `quad_rev_decoder`

## Requirements
- R1: After synchronization, each single-bit change of the {A,B} pair changes the position by one. The sequence 00→10→11→01→00 (A leading) counts up, and the reverse sequence counts down.
- R2: With control bit 1 (filter bypass) at zero, a phase level that lasts fewer than FILT_LEN block clocks is ignored. With bit 1 at one, the filter is skipped.
- R3: With control bit 0 (run) at zero, the position and revolution counts hold. The previous phase state is still tracked, so setting run again does not produce a spurious step.
- R4: Counting up from a position equal to the top value (word 1) gives position 0 and adds one to the revolution count.
- R5: Counting down from position 0 gives the top value and subtracts one from the revolution count, modulo 2^REV_W.
- R6: A change of both phases in one sample is not counted. It sets the sticky error flag in control bit 9, which a write of one to bit 9 clears.
- R7: With control bit 2 (index enable) set, an active index while run is set clears the position to 0 and leaves the revolution count unchanged. This happens only when {A,B} equals control bits 4:3. In any other phase state the index has no effect.
- R8: Control bit 5 enables position compare, and bit 6 enables revolution compare. With one bit set, only that field of word 2 is compared. With both bits set, the whole count must equal the whole compare word.
- R9: On entry into a match, cmp_evt_o is high for exactly one cycle and the flag in control bit 8 is set. The flag stays set until a write of one to bit 8. The interrupt output is this flag ANDed with control bit 7.
- R10: In words 2 and 3, revolution is in bits [31:16] and position in bits [15:0]. A write to word 3 loads both counts.
- R11: After reset, control reads 0, the counts are 0, the compare value is 0, and the top value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| index_i | input | 1 | Encoder index mark (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | POS_W+REV_W | Register write data |
| reg_rdata_o | output | POS_W+REV_W | Register read data for the selected word |
| cmp_irq_o | output | 1 | Masked compare interrupt |
| cmp_evt_o | output | 1 | One-cycle compare event |

## Verification
The bench builds the block with 16-bit position and revolution fields and a filter length of 3. It then programs a top value of 3. A small top makes both wrap directions reachable within a few encoder steps, and it lets the revolution count wrap below zero to all ones. The short filter lets a two-cycle glitch be shown as rejected while a held level still counts. Index phase qualification and all three compare modes are driven against a known count loaded through word 3.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int ADDR_W       = 2;
    localparam int IRQ_FLAG_BIT = 8;
    localparam int ERR_FLAG_BIT = 9;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TOP  = 2'd1,
        REG_CMP  = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // Control word, bit 0 at the bottom
    typedef struct packed {
        logic       irq_en;      // 7
        logic       rev_cmp_en;  // 6
        logic       pos_cmp_en;  // 5
        logic [1:0] idx_phase;   // 4:3, {A,B}
        logic       idx_en;      // 2
        logic       filt_bypass; // 1
        logic       run;         // 0
    } ctrl_t;

    // Classify a move between two sampled {A,B} states
    function automatic step_e decode_step(input logic [1:0] prev, input logic [1:0] cur);
        logic [1:0] diff;
        diff = prev ^ cur;
        if (diff == 2'b00)
            return STEP_NONE;
        else if (diff == 2'b11)
            return STEP_BAD;
        else if (prev[1] == cur[0])
            return STEP_UP;
        else
            return STEP_DOWN;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int W   = 3,
    parameter int LEN = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bypass_i,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [W-1:0] held_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [CW-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[i] <= 1'b0;
                run_q     <= '0;
            end else if (bypass_i) begin
                held_q[i] <= in_i[i];
                run_q     <= '0;
            end else if (in_i[i] == held_q[i]) begin
                run_q <= '0;
            end else if (run_q == CW'(LEN - 1)) begin
                held_q[i] <= in_i[i];
                run_q     <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end

        // R2: a level equal to the held one never moves the filtered output
        a_r2_filter_hold: assert property (@(posedge clk) disable iff (rst)
            (!bypass_i && in_i[i] == held_q[i]) |=> (held_q[i] == $past(held_q[i])));
    end

    assign out_o = bypass_i ? in_i : held_q;
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ab_i,
    input  logic             index_i,
    input  logic             run_i,
    input  logic             idx_en_i,
    input  logic [1:0]       idx_phase_i,
    input  logic [POS_W-1:0] top_i,
    input  logic             load_i,
    input  logic [POS_W-1:0] load_pos_i,
    input  logic [REV_W-1:0] load_rev_i,
    output logic [POS_W-1:0] pos_o,
    output logic [REV_W-1:0] rev_o,
    output logic             bad_o
);
    logic [1:0]       prev_q;
    logic [POS_W-1:0] pos_q;
    logic [REV_W-1:0] rev_q;
    step_e            step;
    logic             idx_hit;

    assign step    = decode_step(prev_q, ab_i);
    assign idx_hit = run_i && idx_en_i && index_i && (ab_i == idx_phase_i);
    assign bad_o   = run_i && (step == STEP_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pos_q  <= '0;
            rev_q  <= '0;
        end else begin
            prev_q <= ab_i;
            if (load_i) begin
                pos_q <= load_pos_i;
                rev_q <= load_rev_i;
            end else if (idx_hit) begin
                pos_q <= '0;
            end else if (run_i) begin
                case (step)
                    STEP_UP: begin
                        if (pos_q >= top_i) begin
                            pos_q <= '0;
                            rev_q <= rev_q + 1'b1;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                    STEP_DOWN: begin
                        if (pos_q == '0) begin
                            pos_q <= top_i;
                            rev_q <= rev_q - 1'b1;
                        end else begin
                            pos_q <= pos_q - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pos_o = pos_q;
    assign rev_o = rev_q;

    // R3: stopped counter holds
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i) |=> ($stable(pos_q) && $stable(rev_q)));

    // R4: upward wrap at top
    a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && !idx_hit && step == STEP_UP && pos_q == top_i)
        |=> (pos_q == '0 && rev_q == $past(rev_q) + 1'b1));

    // R5: downward wrap below zero
    a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && !idx_hit && step == STEP_DOWN && pos_q == '0)
        |=> (pos_q == $past(top_i) && rev_q == $past(rev_q) - 1'b1));

    // R6: a double transition leaves the counts alone
    a_r6_bad_no_count: assert property (@(posedge clk) disable iff (rst)
        (bad_o && !load_i && !idx_hit) |=> ($stable(pos_q) && $stable(rev_q)));

    // R7: accepted index clears position only
    a_r7_index_clear: assert property (@(posedge clk) disable iff (rst)
        (idx_hit && !load_i) |=> (pos_q == '0 && $stable(rev_q)));
endmodule

// File: rtl/quad_rev_decoder.sv
module quad_rev_decoder
    import qdec_pkg::*;
#(
    parameter int POS_W    = 16,
    parameter int REV_W    = 16,
    parameter int FILT_LEN = 3,
    parameter int SYNC_LEN = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   phase_a_i,
    input  logic                   phase_b_i,
    input  logic                   index_i,
    input  logic                   reg_wr_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [POS_W+REV_W-1:0] reg_wdata_i,
    output logic [POS_W+REV_W-1:0] reg_rdata_o,
    output logic                   cmp_irq_o,
    output logic                   cmp_evt_o
);
    localparam int DW = POS_W + REV_W;

    ctrl_t            ctrl_q;
    logic [POS_W-1:0] top_q;
    logic [POS_W-1:0] cmp_pos_q;
    logic [REV_W-1:0] cmp_rev_q;
    logic             irq_flag_q;
    logic             err_flag_q;
    logic             match;
    logic             match_q;

    logic [2:0]       raw_in, sync_in, filt_in;
    logic [POS_W-1:0] pos;
    logic [REV_W-1:0] rev;
    logic             bad;
    logic             wr_ctrl, wr_top, wr_cmp, wr_cnt;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
    assign wr_top  = reg_wr_i && (reg_addr_i == REG_TOP);
    assign wr_cmp  = reg_wr_i && (reg_addr_i == REG_CMP);
    assign wr_cnt  = reg_wr_i && (reg_addr_i == REG_CNT);

    // Input path: {A, B, index}
    assign raw_in = {phase_a_i, phase_b_i, index_i};

    qdec_sync #(.W(3), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    qdec_filter #(.W(3), .LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .bypass_i (ctrl_q.filt_bypass),
        .in_i     (sync_in),
        .out_o    (filt_in)
    );

    qdec_counter #(.POS_W(POS_W), .REV_W(REV_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .ab_i        (filt_in[2:1]),
        .index_i     (filt_in[0]),
        .run_i       (ctrl_q.run),
        .idx_en_i    (ctrl_q.idx_en),
        .idx_phase_i (ctrl_q.idx_phase),
        .top_i       (top_q),
        .load_i      (wr_cnt),
        .load_pos_i  (reg_wdata_i[POS_W-1:0]),
        .load_rev_i  (reg_wdata_i[DW-1:POS_W]),
        .pos_o       (pos),
        .rev_o       (rev),
        .bad_o       (bad)
    );

    // Register file and sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            top_q      <= '1;
            cmp_pos_q  <= '0;
            cmp_rev_q  <= '0;
            irq_flag_q <= 1'b0;
            err_flag_q <= 1'b0;
            match_q    <= 1'b0;
        end else begin
            match_q <= match;
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[7:0]);
            if (wr_top)  top_q  <= reg_wdata_i[POS_W-1:0];
            if (wr_cmp) begin
                cmp_pos_q <= reg_wdata_i[POS_W-1:0];
                cmp_rev_q <= reg_wdata_i[DW-1:POS_W];
            end
            if (cmp_evt_o)
                irq_flag_q <= 1'b1;
            else if (wr_ctrl && reg_wdata_i[IRQ_FLAG_BIT])
                irq_flag_q <= 1'b0;
            if (bad)
                err_flag_q <= 1'b1;
            else if (wr_ctrl && reg_wdata_i[ERR_FLAG_BIT])
                err_flag_q <= 1'b0;
        end
    end

    // Compare unit
    always_comb begin
        case ({ctrl_q.rev_cmp_en, ctrl_q.pos_cmp_en})
            2'b01:   match = (pos == cmp_pos_q);
            2'b10:   match = (rev == cmp_rev_q);
            2'b11:   match = ({rev, pos} == {cmp_rev_q, cmp_pos_q});
            default: match = 1'b0;
        endcase
    end

    assign cmp_evt_o = match && !match_q;
    assign cmp_irq_o = irq_flag_q && ctrl_q.irq_en;

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_sel_e'(reg_addr_i))
            REG_CTRL: begin
                reg_rdata_o[7:0]          = ctrl_q;
                reg_rdata_o[IRQ_FLAG_BIT] = irq_flag_q;
                reg_rdata_o[ERR_FLAG_BIT] = err_flag_q;
            end
            REG_TOP: reg_rdata_o[POS_W-1:0] = top_q;
            REG_CMP: reg_rdata_o = {cmp_rev_q, cmp_pos_q};
            REG_CNT: reg_rdata_o = {rev, pos};
            default: reg_rdata_o = '0;
        endcase
    end

    // R9: event lasts exactly one cycle
    a_r9_evt_single: assert property (@(posedge clk) disable iff (rst)
        cmp_evt_o |=> !cmp_evt_o);

    // R9: event always sets the flag
    a_r9_evt_sets_flag: assert property (@(posedge clk) disable iff (rst)
        cmp_evt_o |=> irq_flag_q);

    // R9: flag stays set without a clearing write
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag_q && !(wr_ctrl && reg_wdata_i[IRQ_FLAG_BIT])) |=> irq_flag_q);

    // R6: error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag_q && !(wr_ctrl && reg_wdata_i[ERR_FLAG_BIT])) |=> err_flag_q);
endmodule

// File: tb/tb_quad_rev_decoder.sv
module tb_quad_rev_decoder;

    localparam int POS_W = 16;
    localparam int REV_W = 16;
    localparam int DW    = POS_W + REV_W;
    localparam int SETTLE = 10;
    localparam int NVEC   = 15;

    // {ab, expected pos, expected rev}, top = 3, starting from ab=00, count 0
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b10, 16'd1, 16'd0},
        {2'b11, 16'd2, 16'd0},
        {2'b01, 16'd3, 16'd0},
        {2'b00, 16'd0, 16'd1},
        {2'b10, 16'd1, 16'd1},
        {2'b00, 16'd0, 16'd1},
        {2'b01, 16'd3, 16'd0},
        {2'b11, 16'd2, 16'd0},
        {2'b01, 16'd3, 16'd0},
        {2'b00, 16'd0, 16'd1},
        {2'b01, 16'd3, 16'd0},
        {2'b11, 16'd2, 16'd0},
        {2'b10, 16'd1, 16'd0},
        {2'b00, 16'd0, 16'd0},
        {2'b01, 16'd3, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pa = 1'b0, pb = 1'b0, idx = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, evt;

    int checks = 0;
    int fails  = 0;
    int evt_cnt = 0;
    logic done = 1'b0;
    logic [1:0] ab = 2'b00;

    always #4 clk = ~clk;

    quad_rev_decoder #(.POS_W(POS_W), .REV_W(REV_W), .FILT_LEN(3)) dut (
        .clk(clk), .rst(rst),
        .phase_a_i(pa), .phase_b_i(pb), .index_i(idx),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .cmp_irq_o(irq), .cmp_evt_o(evt)
    );

    always @(negedge clk) if (!rst && evt) evt_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_ab(input logic [1:0] v);
        @(negedge clk);
        ab = v; pa = v[1]; pb = v[0];
        repeat (SETTLE) @(negedge clk);
    endtask

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] bwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic pulse_index();
        @(negedge clk);
        idx = 1'b1;
        @(negedge clk);
        idx = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        int e0;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rreg(2'd0, r); chk("R11 ctrl", r, 32'h0);
        rreg(2'd1, r); chk("R11 top", r, 32'h0000FFFF);
        rreg(2'd2, r); chk("R11 cmp", r, 32'h0);
        rreg(2'd3, r); chk("R11 count", r, 32'h0);

        // R1 R4 R5 table walk: run + bypass, top 3
        wreg(2'd0, 32'h03);
        wreg(2'd1, 32'd3);
        rreg(2'd1, r); chk("R10 top readback", r, 32'd3);
        for (int i = 0; i < NVEC; i++) begin
            set_ab(VEC[i][33:32]);
            rreg(2'd3, r);
            chk($sformatf("R1 R4 R5 vector %0d", i), r, {VEC[i][15:0], VEC[i][31:16]});
        end

        // R10 load count
        wreg(2'd3, 32'h0);
        rreg(2'd3, r); chk("R10 load", r, 32'h0);

        // R6 double transition: ab 01 -> 10
        set_ab(2'b10);
        rreg(2'd3, r); chk("R6 no count", r, 32'h0);
        rreg(2'd0, r); chk("R6 err set", r[9], 1'b1);
        wreg(2'd0, 32'h203);
        rreg(2'd0, r); chk("R6 err cleared", r[9], 1'b0);

        // R3 stopped
        wreg(2'd0, 32'h02);
        set_ab(fwd(ab));
        rreg(2'd3, r); chk("R3 hold while stopped", r, 32'h0);
        wreg(2'd0, 32'h03);
        set_ab(fwd(ab));
        rreg(2'd3, r); chk("R3 resume no spurious step", r, 32'h1);

        // R7 index with phase qualification 11; ab now 01
        wreg(2'd0, 32'h1F);
        pulse_index();
        rreg(2'd3, r); chk("R7 index wrong phase ignored", r, 32'h1);
        set_ab(2'b11);
        wreg(2'd3, {16'd5, 16'd2});
        pulse_index();
        rreg(2'd3, r); chk("R7 index clears position", r, {16'd5, 16'd0});
        wreg(2'd0, 32'h03);

        // R2 filter active, ab 11
        wreg(2'd0, 32'h01);
        wreg(2'd3, 32'h0);
        @(negedge clk); pa = 1'b0;
        repeat (2) @(negedge clk); pa = 1'b1;
        repeat (SETTLE) @(negedge clk);
        rreg(2'd3, r); chk("R2 glitch rejected", r, 32'h0);
        set_ab(fwd(ab));
        rreg(2'd3, r); chk("R2 held level counted", r, 32'h1);

        // R8 R9 position compare, irq enabled; ab 01 pos 1
        wreg(2'd0, 32'hA3);
        wreg(2'd2, {16'd7, 16'd2});
        e0 = evt_cnt;
        set_ab(fwd(ab));
        chk("R8 pos match event", evt_cnt - e0, 1);
        chk("R9 irq raised", irq, 1'b1);
        set_ab(fwd(ab));
        chk("R9 no event off match", evt_cnt - e0, 1);
        set_ab(bwd(ab));
        chk("R9 re-entry event", evt_cnt - e0, 2);
        wreg(2'd0, 32'h1A3);
        rreg(2'd0, r); chk("R9 flag cleared", r[8], 1'b0);
        chk("R9 irq low after clear", irq, 1'b0);
        wreg(2'd0, 32'h23);
        set_ab(fwd(ab));
        set_ab(bwd(ab));
        chk("R9 masked event", evt_cnt - e0, 3);
        chk("R9 irq masked", irq, 1'b0);
        rreg(2'd0, r); chk("R9 flag set while masked", r[8], 1'b1);
        wreg(2'd0, 32'h123);

        // R8 revolution compare
        wreg(2'd0, 32'h43);
        e0 = evt_cnt;
        wreg(2'd3, {16'd7, 16'd0});
        repeat (2) @(negedge clk);
        chk("R8 rev match event", evt_cnt - e0, 1);

        // R8 joint compare; ab 00
        wreg(2'd0, 32'h63);
        e0 = evt_cnt;
        wreg(2'd3, {16'd7, 16'd1});
        repeat (2) @(negedge clk);
        chk("R8 joint partial no event", evt_cnt - e0, 0);
        set_ab(fwd(ab));
        chk("R8 joint full match event", evt_cnt - e0, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule